// File: doc/BRIEF.md
# Two-Class Preemptive Event Dispatcher

This block decides which event handler a small processor core runs next. External happenings such as sensor triggers arrive as one-cycle request pulses on one of two classes, urgent or routine, each pulse carrying a small handler number. Each class has its own short first-in first-out queue, so requests of one class are always served in the order they came in.

When the core is idle, or the current handler reports completion, the dispatcher pops the next entry. It prefers the urgent queue. It drives the handler number, a register-bank select and a one-cycle dispatch strobe. An urgent request that arrives while a routine handler runs preempts it at once. The bank select moves to the urgent register set, so the interrupted routine work keeps its registers and control state untouched. When all urgent work has drained, the interrupted routine handler resumes on its own bank before any new routine entry is dispatched. Urgent handlers are never preempted. A completion pulse with no handler active is ignored and latches an error flag. A request that finds its queue full is dropped and latches that class's overflow flag.

Top module: `evt_sched`

## Requirements
- R1: After reset, act_valid, dispatch, bank_sel, hi_ovf, lo_ovf and done_err are all 0.
- R2: A request accepted at clock edge N while the core is idle is dispatched at edge N+1: dispatch=1, act_valid=1, act_id equals the request id, and bank_sel=1 for an urgent request or bank_sel=0 for a routine one.
- R3: Routine requests are dispatched strictly in arrival order.
- R4: Urgent requests are dispatched strictly in arrival order.
- R5: An urgent request accepted at edge N while a routine handler runs preempts it at edge N+1: dispatch=1, bank_sel=1, act_id = urgent id.
- R6: An urgent handler is never preempted. A further urgent request waits in its queue, and act_id and bank_sel hold until done.
- R7: When urgent work finishes and the urgent queue is empty, the preempted routine handler resumes at the next edge with its own act_id and bank_sel=0, and dispatch stays 0. It resumes ahead of any queued routine entry.
- R8: Each queue holds DEPTH entries (default 4). A request arriving at a full queue is dropped and sets that class's sticky overflow flag (hi_ovf or lo_ovf).
- R9: When both queues hold entries at a dispatch point, the urgent entry is dispatched first.
- R10: dispatch is high for exactly one cycle per dispatched entry, and bank_sel takes its new value in that same cycle.
- R11: done while act_valid=0 changes no handler state and sets the sticky done_err flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_req | input | 1 | Urgent request pulse |
| hi_id | input | ID_W | Handler number of the urgent request |
| lo_req | input | 1 | Routine request pulse |
| lo_id | input | ID_W | Handler number of the routine request |
| done | input | 1 | Current handler has finished |
| act_valid | output | 1 | A handler is active |
| act_id | output | ID_W | Handler number now active |
| bank_sel | output | 1 | Register bank: 1 urgent, 0 routine |
| dispatch | output | 1 | One-cycle strobe for a newly dispatched entry |
| hi_ovf | output | 1 | Sticky urgent queue overflow |
| lo_ovf | output | 1 | Sticky routine queue overflow |
| done_err | output | 1 | Sticky flag for done with nothing active |

## Verification
The assertions check these rules on every cycle: an urgent handler holds its number and bank until done, a routine handler holds while no urgent work is queued, a queued urgent entry always takes over a routine handler at the next edge, the overflow flags stay set, and a stray done raises the error flag. Only the bench scenarios can show the properties that depend on order. These are the arrival order within each class, a dropped fifth entry, the resumed routine handler coming before a queued routine entry, and urgent-first choice when both queues are loaded.

// File: rtl/evt_sched_pkg.sv
package evt_sched_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LO   = 2'd1,
      ST_HI   = 2'd2,
      ST_HI_S = 2'd3
   } sched_st_e;
endpackage

// File: rtl/evt_fifo.sv
module evt_fifo #(
   parameter int ID_W  = 4,
   parameter int DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ID_W-1:0]   din,
   input  logic              pop,
   output logic [ID_W-1:0]   dout,
   output logic              not_empty,
   output logic              ovf,
   output logic [$clog2(DEPTH):0] count
);
   localparam int PTR_W = $clog2(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("evt_fifo: DEPTH must be at least 2");
   end
   if ((1 << PTR_W) != DEPTH) begin : g_bad_pow2
      $error("evt_fifo: DEPTH must be a power of two");
   end

   logic [ID_W-1:0]  mem [DEPTH];
   logic [PTR_W-1:0] wptr, rptr;
   logic             full, do_push, do_pop;

   assign full      = (count == DEPTH[PTR_W:0]);
   assign not_empty = (count != '0);
   assign do_push   = push && !full;
   assign do_pop    = pop && not_empty;
   assign dout      = mem[rptr];

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)
            mem[i] <= '0;
         else if (do_push && (wptr == PTR_W'(i)))
            mem[i] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
         ovf   <= 1'b0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         if (push && full) ovf <= 1'b1;
      end
   end
endmodule

// File: rtl/evt_ctrl.sv
module evt_ctrl
   import evt_sched_pkg::*;
#(
   parameter int ID_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hi_ne,
   input  logic [ID_W-1:0] hi_head,
   input  logic            lo_ne,
   input  logic [ID_W-1:0] lo_head,
   input  logic            done,
   output logic            hi_pop,
   output logic            lo_pop,
   output logic            act_valid,
   output logic [ID_W-1:0] act_id,
   output logic            bank_sel,
   output logic            dispatch,
   output logic            done_err
);
   sched_st_e       st, st_nx;
   logic [ID_W-1:0] id_nx, saved_id;
   logic            disp_nx, save_lo;

   always_comb begin
      st_nx   = st;
      id_nx   = act_id;
      disp_nx = 1'b0;
      hi_pop  = 1'b0;
      lo_pop  = 1'b0;
      save_lo = 1'b0;
      unique case (st)
         ST_LO: begin
            if (!done && hi_ne) begin
               st_nx   = ST_HI_S;
               id_nx   = hi_head;
               hi_pop  = 1'b1;
               disp_nx = 1'b1;
               save_lo = 1'b1;
            end
         end
         ST_HI_S: begin
            if (done) begin
               if (hi_ne) begin
                  id_nx   = hi_head;
                  hi_pop  = 1'b1;
                  disp_nx = 1'b1;
               end else begin
                  st_nx = ST_LO;
                  id_nx = saved_id;
               end
            end
         end
         default: ;
      endcase
      if ((st == ST_IDLE) || (done && (st == ST_LO || st == ST_HI))) begin
         if (hi_ne) begin
            st_nx   = ST_HI;
            id_nx   = hi_head;
            hi_pop  = 1'b1;
            disp_nx = 1'b1;
         end else if (lo_ne) begin
            st_nx   = ST_LO;
            id_nx   = lo_head;
            lo_pop  = 1'b1;
            disp_nx = 1'b1;
         end else begin
            st_nx = ST_IDLE;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         act_id   <= '0;
         saved_id <= '0;
         dispatch <= 1'b0;
         done_err <= 1'b0;
      end else begin
         st       <= st_nx;
         act_id   <= id_nx;
         dispatch <= disp_nx;
         if (save_lo) saved_id <= act_id;
         if (done && st == ST_IDLE) done_err <= 1'b1;
      end
   end

   assign act_valid = (st != ST_IDLE);
   assign bank_sel  = (st == ST_HI) || (st == ST_HI_S);
endmodule

// File: rtl/evt_sched.sv
module evt_sched #(
   parameter int ID_W  = 4,
   parameter int DEPTH = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hi_req,
   input  logic [ID_W-1:0] hi_id,
   input  logic            lo_req,
   input  logic [ID_W-1:0] lo_id,
   input  logic            done,
   output logic            act_valid,
   output logic [ID_W-1:0] act_id,
   output logic            bank_sel,
   output logic            dispatch,
   output logic            hi_ovf,
   output logic            lo_ovf,
   output logic            done_err
);
   localparam int CNT_W = $clog2(DEPTH) + 1;

   if (ID_W < 1) begin : g_bad_idw
      $error("evt_sched: ID_W must be positive");
   end

   logic [ID_W-1:0]  hi_head, lo_head;
   logic             hi_ne, lo_ne, hi_pop, lo_pop;
   logic [CNT_W-1:0] hi_cnt, lo_cnt;

   evt_fifo #(.ID_W(ID_W), .DEPTH(DEPTH)) u_hi_q (
      .clk(clk), .rst_n(rst_n), .push(hi_req), .din(hi_id), .pop(hi_pop),
      .dout(hi_head), .not_empty(hi_ne), .ovf(hi_ovf), .count(hi_cnt)
   );

   evt_fifo #(.ID_W(ID_W), .DEPTH(DEPTH)) u_lo_q (
      .clk(clk), .rst_n(rst_n), .push(lo_req), .din(lo_id), .pop(lo_pop),
      .dout(lo_head), .not_empty(lo_ne), .ovf(lo_ovf), .count(lo_cnt)
   );

   evt_ctrl #(.ID_W(ID_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .hi_ne(hi_ne), .hi_head(hi_head),
      .lo_ne(lo_ne), .lo_head(lo_head), .done(done),
      .hi_pop(hi_pop), .lo_pop(lo_pop), .act_valid(act_valid),
      .act_id(act_id), .bank_sel(bank_sel), .dispatch(dispatch),
      .done_err(done_err)
   );
endmodule

// File: rtl/evt_sched_chk.sv
module evt_sched_chk #(
   parameter int ID_W  = 4,
   parameter int CNT_W = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            done,
   input logic            act_valid,
   input logic [ID_W-1:0] act_id,
   input logic            bank_sel,
   input logic            dispatch,
   input logic            hi_ovf,
   input logic            lo_ovf,
   input logic            done_err,
   input logic [CNT_W-1:0] hi_cnt
);
   // R10
   disp_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dispatch |-> act_valid);

   // R6
   hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_valid && bank_sel && !done) |=>
         (act_valid && bank_sel && $stable(act_id) && !dispatch));

   // R5
   preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_valid && !bank_sel && hi_cnt != '0) |=> (bank_sel && dispatch));

   // R3
   lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_valid && !bank_sel && !done && hi_cnt == '0) |=>
         (act_valid && !bank_sel && $stable(act_id)));

   // R8
   hi_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hi_ovf |=> hi_ovf);

   // R8
   lo_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lo_ovf |=> lo_ovf);

   // R11
   stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !act_valid) |=> done_err);
endmodule

bind evt_sched evt_sched_chk #(.ID_W(ID_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .done(done), .act_valid(act_valid),
   .act_id(act_id), .bank_sel(bank_sel), .dispatch(dispatch),
   .hi_ovf(hi_ovf), .lo_ovf(lo_ovf), .done_err(done_err), .hi_cnt(hi_cnt)
);

// File: tb/sim_evt_sched.sv
module sim_evt_sched;
   localparam int ID_W = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            hi_req = 1'b0, lo_req = 1'b0, done = 1'b0;
   logic [ID_W-1:0] hi_id = '0, lo_id = '0;
   logic            act_valid, bank_sel, dispatch, hi_ovf, lo_ovf, done_err;
   logic [ID_W-1:0] act_id;
   int              n_chk = 0, n_fail = 0;
   bit              finished = 1'b0;

   always #5 clk = ~clk;

   evt_sched #(.ID_W(ID_W), .DEPTH(4)) u0 (
      .clk(clk), .rst_n(rst_n), .hi_req(hi_req), .hi_id(hi_id),
      .lo_req(lo_req), .lo_id(lo_id), .done(done),
      .act_valid(act_valid), .act_id(act_id), .bank_sel(bank_sel),
      .dispatch(dispatch), .hi_ovf(hi_ovf), .lo_ovf(lo_ovf),
      .done_err(done_err)
   );

   task automatic chk(input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic push_hi(input int id);
      hi_req = 1'b1; hi_id = ID_W'(id); cyc(); hi_req = 1'b0;
   endtask

   task automatic push_lo(input int id);
      lo_req = 1'b1; lo_id = ID_W'(id); cyc(); lo_req = 1'b0;
   endtask

   task automatic fin();
      done = 1'b1; cyc(); done = 1'b0;
   endtask

   task automatic expect_run(input string req, input int id, input int bank,
                             input int disp);
      chk(req, "act_valid", act_valid, 1);
      chk(req, "act_id", act_id, id);
      chk(req, "bank_sel", bank_sel, bank);
      chk(req, "dispatch", dispatch, disp);
   endtask

   task automatic t_reset();
      chk("R1", "act_valid", act_valid, 0);
      chk("R1", "dispatch", dispatch, 0);
      chk("R1", "bank_sel", bank_sel, 0);
      chk("R1", "ovf", {hi_ovf, lo_ovf}, 0);
      chk("R1", "done_err", done_err, 0);
   endtask

   task automatic t_single();
      push_lo(6); cyc();
      expect_run("R2", 6, 0, 1);
      cyc();
      chk("R10", "dispatch one cycle", dispatch, 0);
      fin();
      chk("R2", "idle after done", act_valid, 0);
      push_hi(11); cyc();
      expect_run("R2", 11, 1, 1);
      fin();
      chk("R2", "idle after hi done", act_valid, 0);
   endtask

   task automatic t_preempt();
      push_lo(3); cyc();
      expect_run("R5", 3, 0, 1);
      push_lo(4);
      chk("R3", "queued lo waits", act_id, 3);
      push_hi(9); cyc();
      expect_run("R5", 9, 1, 1);
      fin();
      expect_run("R7", 3, 0, 0);
      fin();
      expect_run("R7", 4, 0, 1);
      fin();
      chk("R7", "idle", act_valid, 0);
   endtask

   task automatic t_hi_order();
      push_hi(1); cyc();
      expect_run("R6", 1, 1, 1);
      for (int k = 2; k <= 6; k++) push_hi(k);
      expect_run("R6", 1, 1, 0);
      chk("R8", "hi_ovf", hi_ovf, 1);
      for (int k = 2; k <= 5; k++) begin
         fin();
         expect_run("R4", k, 1, 1);
      end
      fin();
      chk("R8", "sixth hi dropped", act_valid, 0);
   endtask

   task automatic t_lo_order();
      push_hi(13); cyc();
      for (int k = 1; k <= 5; k++) push_lo(k);
      chk("R8", "lo_ovf", lo_ovf, 1);
      for (int k = 1; k <= 4; k++) begin
         fin();
         expect_run("R3", k, 0, 1);
      end
      fin();
      chk("R8", "fifth lo dropped", act_valid, 0);
   endtask

   task automatic t_both();
      push_hi(12); cyc();
      push_lo(7);
      push_hi(8);
      fin();
      expect_run("R9", 8, 1, 1);
      fin();
      expect_run("R9", 7, 0, 1);
      fin();
      chk("R9", "idle", act_valid, 0);
   endtask

   task automatic t_stray();
      fin();
      chk("R11", "done_err", done_err, 1);
      chk("R11", "act_valid", act_valid, 0);
      chk("R11", "dispatch", dispatch, 0);
   endtask

   initial begin
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
      t_reset();
      t_single();
      t_preempt();
      t_hi_order();
      t_lo_order();
      t_both();
      t_stray();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule